// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector

This block compares a reference clock with a feedback clock and drives two
control outputs, `up` and `dn`, for a downstream charge pump. Both inputs are
oversampled by a fast system clock. Each goes through a synchronizer and a
rising-edge detector. A small state machine then records which input moved
first and holds the matching output high until the other input catches up.

When the lagging edge arrives, both outputs are held high together for a
programmable number of cycles, then both clear. Because of this overlap, even a
one-cycle phase error still gives a pulse of at least a known width, so the loop
has no dead zone. The net correction is the time `up` is high minus the time
`dn` is high.

A mode input removes frequency tracking for delay-locked loops. In that mode,
repeated edges on the same input are dropped rather than starting a new pulse.

Top module: `phase_freq_det`

## Requirements
- R1: While `rst_n` is low at a clock edge, `up` and `dn` are both 0 after that edge, and a pulse in progress is cleared.
- R2: A rising edge on `ref_in` that is stable over one clock edge shows on `up` three clock edges later: two synchronizer stages, one edge-detect stage, then the state register.
- R3: From the idle state (both outputs 0), a lone reference edge raises `up` only and a lone feedback edge raises `dn` only. An output never rises without a detected edge on its own input in the cycle before.
- R4: While one output is high, an edge on the other input raises that other output too. Both then stay high for `min_width`+1 cycles, and afterwards both are 0 together.
- R5: `min_width` is read when the overlap starts. A value of 0 gives exactly one cycle of overlap, and 15 gives sixteen.
- R6: For one reference edge and one feedback edge that are d cycles apart (d ≠ 0), the leading output is high for |d|+`min_width`+1 cycles and the lagging one for `min_width`+1 cycles, so their difference is d.
- R7: Reference and feedback edges detected in the same cycle while idle leave both outputs at 0. The two outputs never rise in the same cycle.
- R8: A further edge on the input whose output is already the only one high changes nothing: the pulse keeps running until the other input's edge.
- R9: Edges on either input while both outputs are high are ignored. The overlap ends on time and the block returns to idle.
- R10: With `phase_only` = 0, an edge on either input while idle starts a pulse, whatever the input of the previous edge was.
- R11: With `phase_only` = 1, an edge while idle is ignored if the last edge the block acted on came from the same input. After reset either input may start a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples both inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| fb_in | input | 1 | Feedback clock, asynchronous to `clk` |
| phase_only | input | 1 | 1 selects phase-only (delay-locked loop) behaviour, 0 selects phase-frequency behaviour |
| min_width | input | 4 | Extra overlap cycles added when both outputs are high |
| up | output | 1 | Request to speed up / advance the feedback |
| dn | output | 1 | Request to slow down / retard the feedback |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a 4-bit width count. With these values it can sweep every `min_width` from 0 to 15 against every signed edge offset from -7 to +7 cycles, in both modes. For each run it checks the cycles `up` is high, the cycles `dn` is high and the cycles they overlap against |d|+w+1 and w+1. The short 4-bit count keeps that full cross product small. Directed edge sequences then separate the two modes, probe edges that fall inside an overlap, and measure the exact three-edge latency.

// File: rtl/pfd_pkg.sv
// Package: shared types for the phase-frequency detector.
// Assumes: nothing beyond IEEE 1800-2017.
package pfd_pkg;

    // Detector control state.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LEAD_UP = 2'd1,
        ST_LEAD_DN = 2'd2,
        ST_OVERLAP = 2'd3
    } pfd_state_t;

    // Which input supplied the last edge the detector acted on.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_REF  = 2'd1,
        SRC_FB   = 2'd2
    } pfd_src_t;

endpackage

// File: rtl/pfd_edge_sync.sv
// Module: pfd_edge_sync
// Brings an asynchronous input into the clk domain through a flop chain,
// then gives a one-cycle pulse for each rising edge seen at the chain output.
// Assumes: STAGES >= 2; the input is slow compared with clk.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Hold the last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    // Rising edge: synchronized level is high now and was low one cycle ago.
    always_comb rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/pfd_hold_timer.sv
// Module: pfd_hold_timer
// Down-counter that times the overlap. It loads the width value on start,
// then counts down to zero and holds there.
// Assumes: start is a single-cycle pulse from the controller.
module pfd_hold_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Expired once the count has reached zero.
    always_comb expired = (cnt == '0);

endmodule

// File: rtl/pfd_ctrl.sv
// Module: pfd_ctrl
// Detector state machine. Moves from idle to a lead state on the first edge,
// into overlap on the other input's edge, and back to idle when the hold
// timer expires. It remembers the source of the last edge it acted on, so that
// phase-only mode can drop repeated edges.
// Assumes: ref_rise and fb_rise are one-cycle pulses synchronous to clk.
module pfd_ctrl
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    input  logic phase_only,
    input  logic hold_done,
    output logic hold_start,
    output logic up,
    output logic dn
);

    pfd_state_t state, state_nx;
    pfd_src_t   last_src, last_src_nx;
    logic       ref_ok, fb_ok;

    // Phase-only mode refuses an edge from the same input as the last one used.
    always_comb begin
        ref_ok = ref_rise && (!phase_only || last_src != SRC_REF);
        fb_ok  = fb_rise  && (!phase_only || last_src != SRC_FB);
    end

    // Next-state and start-of-overlap decode.
    always_comb begin
        state_nx    = state;
        last_src_nx = last_src;
        hold_start  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_rise && fb_rise) begin
                    state_nx = ST_IDLE;
                end else if (ref_ok) begin
                    state_nx    = ST_LEAD_UP;
                    last_src_nx = SRC_REF;
                end else if (fb_ok) begin
                    state_nx    = ST_LEAD_DN;
                    last_src_nx = SRC_FB;
                end
            end
            ST_LEAD_UP: begin
                if (fb_rise) begin
                    state_nx    = ST_OVERLAP;
                    last_src_nx = SRC_FB;
                    hold_start  = 1'b1;
                end
            end
            ST_LEAD_DN: begin
                if (ref_rise) begin
                    state_nx    = ST_OVERLAP;
                    last_src_nx = SRC_REF;
                    hold_start  = 1'b1;
                end
            end
            ST_OVERLAP: begin
                if (hold_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and edge-source registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            last_src <= SRC_NONE;
        end else begin
            state    <= state_nx;
            last_src <= last_src_nx;
        end
    end

    // Outputs decoded from the registered state only.
    always_comb begin
        up = (state == ST_LEAD_UP) || (state == ST_OVERLAP);
        dn = (state == ST_LEAD_DN) || (state == ST_OVERLAP);
    end

endmodule

// File: rtl/phase_freq_det.sv
// Module: phase_freq_det (top)
// Oversampled phase-frequency detector with a programmable minimum overlap
// and a phase-only mode.
// Assumes: ref_in and fb_in toggle slower than clk; min_width is quasi-static.
module phase_freq_det #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             phase_only,
    input  logic [CNT_W-1:0] min_width,
    output logic             up,
    output logic             dn
);

    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise_vec;
    logic            ref_rise, fb_rise;
    logic            hold_start, hold_done;

    // Gather both inputs so one synchronizer is generated per input.
    always_comb raw_in = {fb_in, ref_in};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[gi]),
            .rise (rise_vec[gi])
        );
    end

    // Name the edge pulses by input.
    always_comb begin
        ref_rise = rise_vec[0];
        fb_rise  = rise_vec[1];
    end

    pfd_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (hold_start),
        .load_val(min_width),
        .expired (hold_done)
    );

    pfd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (ref_rise),
        .fb_rise   (fb_rise),
        .phase_only(phase_only),
        .hold_done (hold_done),
        .hold_start(hold_start),
        .up        (up),
        .dn        (dn)
    );

endmodule

// File: rtl/pfd_checker.sv
// Module: pfd_checker
// Property checks for phase_freq_det. Attached to the top module by bind.
// Assumes: min_width does not change while an overlap is in progress.
module pfd_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up,
    input logic             dn,
    input logic             ref_rise,
    input logic             fb_rise,
    input logic [CNT_W-1:0] min_width
);

    logic             was_rst;
    logic [CNT_W:0]   ov_cnt;
    logic [CNT_W-1:0] ov_lim;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Count overlap cycles, and freeze the width limit while overlapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_cnt <= '0;
            ov_lim <= '0;
        end else begin
            ov_cnt <= (up && dn) ? ov_cnt + 1'b1 : '0;
            if (!(up && dn)) ov_lim <= min_width;
        end
    end

    // p_reset_clear_r1: outputs are low after a reset edge.
    always_ff @(posedge clk) begin
        if (was_rst) p_reset_clear_r1: assert (!up && !dn);
    end

    p_up_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up) |-> $past(ref_rise));

    p_dn_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn) |-> $past(fb_rise));

    p_overlap_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |-> (ov_cnt <= {1'b0, ov_lim}));

    p_overlap_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up && dn) |-> (!up && !dn));

    p_no_joint_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(up) && $rose(dn)));

endmodule

bind phase_freq_det pfd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up       (up),
    .dn       (dn),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .min_width(min_width)
);

// File: tb/phase_freq_det_tb.sv
// Bench: sweeps edge offset x overlap width x mode, then directed sequences.
module phase_freq_det_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       phase_only = 1'b0;
    logic [3:0] min_width = 4'd0;
    logic       up, dn;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int cnt_up, cnt_dn, cnt_ov;

    phase_freq_det u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .phase_only(phase_only), .min_width(min_width), .up(up), .dn(dn)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Runs a window of negedges. An input is high only at its listed times
    // (-1 = unused). Counts up, dn and overlap samples, taken before driving.
    task automatic run_win(input int len, input int r0, input int r1,
                           input int f0, input int f1);
        cnt_up = 0; cnt_dn = 0; cnt_ov = 0;
        for (int i = 0; i < len; i++) begin
            if (up) cnt_up++;
            if (dn) cnt_dn++;
            if (up && dn) cnt_ov++;
            ref_in = (i == r0) || (i == r1);
            fb_in  = (i == f0) || (i == f1);
            @(negedge clk);
        end
        ref_in = 1'b0; fb_in = 1'b0;
    endtask

    initial begin
        int lead, lag, ov;

        // R1: reset state.
        do_reset();
        check("R1 up after reset", up, 0);
        check("R1 dn after reset", dn, 0);

        // R2: latency of three clock edges.
        phase_only = 1'b0; min_width = 4'd0;
        ref_in = 1'b1;
        @(negedge clk); ref_in = 1'b0;
        @(negedge clk);
        check("R2 up two edges after input", up, 0);
        @(negedge clk);
        check("R2 up three edges after input", up, 1);
        check("R3 dn stays low on lone ref edge", dn, 0);

        // R1: a reset in the middle of a pulse clears it.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 up cleared mid-pulse", up, 0);
        rst_n = 1'b1;

        // Sweep: R3 R4 R5 R6 R7 over offset, width and mode.
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 16; w++) begin
                for (int d = -7; d <= 7; d++) begin
                    do_reset();
                    phase_only = logic'(m);
                    min_width  = 4'(w);
                    if (d >= 0) run_win(40, 0, -1, d, -1);
                    else        run_win(40, -d, -1, 0, -1);
                    if (d == 0) begin
                        check("R7 simultaneous up", cnt_up, 0);
                        check("R7 simultaneous dn", cnt_dn, 0);
                    end else begin
                        lead = (d > 0 ? d : -d) + w + 1;
                        lag  = w + 1;
                        check("R6 up cycles", cnt_up, d > 0 ? lead : lag);
                        check("R6 dn cycles", cnt_dn, d > 0 ? lag : lead);
                        check("R5 overlap cycles", cnt_ov, w + 1);
                        check("R4 net up-dn", cnt_up - cnt_dn, d);
                    end
                end
            end
        end

        // R8 R10: phase-frequency mode, ref,ref,fb,fb with w=2.
        do_reset();
        phase_only = 1'b0; min_width = 4'd2;
        run_win(40, 0, 6, 12, 18);
        check("R8 saturated up cycles", cnt_up, 15);
        check("R10 repeated fb opens dn", cnt_dn, 3 + (40 - 21));

        // R11: the same sequence in phase-only mode.
        do_reset();
        phase_only = 1'b1; min_width = 4'd2;
        run_win(40, 0, 6, 12, 18);
        check("R11 phase-only up cycles", cnt_up, 15);
        check("R11 phase-only repeated fb ignored", cnt_dn, 3);

        // R9: ref edge inside an overlap is ignored, w=5.
        do_reset();
        phase_only = 1'b0; min_width = 4'd5;
        run_win(40, 0, 5, 3, -1);
        check("R9 up cycles", cnt_up, 9);
        check("R9 dn cycles", cnt_dn, 6);
        check("R9 idle after overlap up", up, 0);
        check("R9 idle after overlap dn", dn, 0);

        // R3: lone fb edge raises dn only.
        do_reset();
        ov = 0;
        run_win(10, -1, -1, 0, -1);
        check("R3 dn on lone fb", dn, 1);
        check("R3 up low on lone fb", up, ov);

        finish_run();
    end

endmodule